// File: doc/BRIEF.md
# Three-Channel Register-Controlled PWM Bank

This block drives three pulse-width-modulated outputs, for example fan drives. A host reaches it through a small register port that has an 8-bit address, a single-cycle synchronous write and a combinational read. Each channel has two registers: a duty register and a setup register. The top three bits of the setup register choose who owns the channel's duty. The host owns it in manual mode. In every other mode an external control loop owns it, and that loop arrives on the `auto_duty` input bus.

A read of a duty register always returns the duty value the channel is using at that moment, whichever mode is active. Software can therefore watch the automatic loop at work. Each output runs a 256-step period. Each step lasts `PRESCALE` clocks. A new duty value waits for the next period boundary, so the output never produces a shortened or extra pulse.

The register port is plain control: it has no handshake and never stalls. There is no streaming interface.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every duty register and every setup register reads 0x00, and all three outputs are low.
- R2: The duty registers of channels 0, 1 and 2 sit at addresses 0x30, 0x31 and 0x32. The setup registers sit at 0x5C, 0x5D and 0x5E. A setup register reads back the full byte last written to it.
- R3: When bits 7:5 of a channel's setup register equal 3'b111 (manual mode), a write to its duty register stores the written byte. The stored byte is read back and held until the next write.
- R4: When bits 7:5 hold any value other than 3'b111, writes to the duty register are ignored. The register instead follows the channel's 8-bit slice of `auto_duty` (channel n at bits 8n+7:8n), one clock later.
- R5: Each output has a period of 256×PRESCALE clocks. The output is high for the first duty×PRESCALE clocks of the period, so 0x80 gives 50% and 0x54 gives about 33%.
- R6: A duty of 0x00 keeps the output low. A duty of 0xFF keeps the output high for the whole period.
- R7: A changed duty value takes effect only at the start of the next period, and the output changes level only on prescaler steps.
- R8: A read of any unmapped address returns 0x00. A write to an unmapped address changes no register.
- R9: Each channel's registers and output are independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| auto_duty | input | 24 | Duty requested by the automatic loop; channel n uses bits 8n+7:8n |
| pwm_out | output | 3 | PWM waveforms; bit n belongs to channel n |

## Verification
The assertions assume that `addr`, `wr_en` and `wdata` are known and settled at every rising edge, so that at most one register is chosen for a write in any cycle. They also assume that `auto_duty` may change at any clock but has no unknown bits. The bench drives all inputs at the falling edge and holds them steady across each rising edge. It sets `auto_duty` to known values from time zero, and it makes a mid-period duty change only after lining up with an observed period start.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam logic [2:0] MODE_MANUAL = 3'b111;

  function automatic logic is_manual(input logic [2:0] mode_field);
    return mode_field == MODE_MANUAL;
  endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRESCALE = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE == 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_count
      logic [CW-1:0] div_q;
      assign tick = (div_q == CW'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
      // Steps are never back to back when the divider is in use
      p_tick_spaced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_bank_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] DUTY_ADDR = 8'h30,
  parameter logic [AW-1:0] CFG_ADDR  = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] auto_duty,
  output logic [DW-1:0] duty_q,
  output logic [DW-1:0] cfg_q
);
  logic duty_hit, cfg_hit, manual;

  assign duty_hit = wr_en && (addr == DUTY_ADDR);
  assign cfg_hit  = wr_en && (addr == CFG_ADDR);
  assign manual   = is_manual(cfg_q[DW-1 -: 3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (cfg_hit) cfg_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        duty_q <= '0;
    else if (!manual)  duty_q <= auto_duty;
    else if (duty_hit) duty_q <= wdata;
  end

  p_manual_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && duty_hit) |=> (duty_q == $past(wdata)));
  p_manual_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && !duty_hit) |=> $stable(duty_q));
  p_auto_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !manual |=> (duty_q == $past(auto_duty)));
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] duty_in,
  output logic          pwm
);
  logic [DW-1:0] phase_q, live_q;
  logic          wrap;

  assign wrap = tick && (phase_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      live_q  <= '0;
    end else begin
      if (tick) phase_q <= phase_q + 1'b1;
      if (wrap) live_q  <= duty_in;
    end
  end

  assign pwm = (live_q == '1) || (phase_q < live_q);

  p_latch_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(live_q));
  p_edge_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH      = 3,
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int PRESCALE = 2,
  parameter logic [AW-1:0] DUTY_BASE = 8'h30,
  parameter logic [AW-1:0] CFG_BASE  = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH*DW-1:0] auto_duty,
  output logic [NCH-1:0]    pwm_out
);
  logic          tick;
  logic [DW-1:0] duty_arr [NCH];
  logic [DW-1:0] cfg_arr  [NCH];

  pwm_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      pwm_chan_regs #(
        .DW(DW), .AW(AW),
        .DUTY_ADDR(AW'(DUTY_BASE + g)),
        .CFG_ADDR (AW'(CFG_BASE + g))
      ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .auto_duty(auto_duty[g*DW +: DW]),
        .duty_q(duty_arr[g]), .cfg_q(cfg_arr[g])
      );
      pwm_chan_gen #(.DW(DW)) u_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .duty_in(duty_arr[g]), .pwm(pwm_out[g])
      );
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(DUTY_BASE + i)) rdata = duty_arr[i];
      if (addr == AW'(CFG_BASE + i))  rdata = cfg_arr[i];
    end
  end
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [23:0] auto_duty = 24'h0;
  logic [2:0]  pwm_out;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwm_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .auto_duty(auto_duty), .pwm_out(pwm_out)
  );

  // {channel, manual flag, duty, expected high clocks per 512-clock period}
  localparam logic [39:0] VEC [8] = '{
    {8'd0, 8'd1, 8'h80, 16'd256},
    {8'd1, 8'd1, 8'h54, 16'd168},
    {8'd2, 8'd1, 8'hFF, 16'd512},
    {8'd0, 8'd1, 8'h00, 16'd0},
    {8'd1, 8'd0, 8'h20, 16'd64},
    {8'd2, 8'd0, 8'h01, 16'd2},
    {8'd0, 8'd0, 8'hFE, 16'd508},
    {8'd1, 8'd1, 8'h10, 16'd32}
  };

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic measure(input int ch, output int hi);
    hi = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int hi;
    logic prev;

    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      rd(8'h30 + 8'(a), d); check("R1 duty reset", d, 0);
      rd(8'h5C + 8'(a), d); check("R1 cfg reset", d, 0);
    end
    check("R1 outputs low", pwm_out, 0);
    rst_n = 1'b1;

    // R3..R6 table walk
    for (int v = 0; v < 8; v++) begin
      int ch; logic man; logic [7:0] du; int exph;
      ch = int'(VEC[v][39:32]); man = VEC[v][24]; du = VEC[v][23:16];
      exph = int'(VEC[v][15:0]);
      if (man) begin
        wr(8'h5C + 8'(ch), 8'hE0 | 8'(ch));
        rd(8'h5C + 8'(ch), d); check("R2 cfg readback", d, 8'hE0 | 8'(ch));
        wr(8'h30 + 8'(ch), du);
        rd(8'h30 + 8'(ch), d); check("R3 manual duty readback", d, du);
      end else begin
        wr(8'h5C + 8'(ch), 8'h40);
        auto_duty[ch*8 +: 8] = du;
        wr(8'h30 + 8'(ch), ~du);
        rd(8'h30 + 8'(ch), d); check("R4 auto duty readback", d, du);
      end
      repeat (1100) @(negedge clk);
      measure(ch, hi);
      check(du == 8'hFF || du == 8'h00 ? "R6 period high count" : "R5 period high count", hi, exph);
    end

    // R9: other channels kept their own values
    rd(8'h30, d); check("R9 ch0 duty", d, 8'hFE);
    rd(8'h31, d); check("R9 ch1 duty", d, 8'h10);
    rd(8'h32, d); check("R9 ch2 duty", d, 8'h01);

    // R8: unmapped addresses
    wr(8'h33, 8'h77);
    wr(8'h2F, 8'h55);
    wr(8'h5F, 8'hAA);
    rd(8'h33, d); check("R8 unmapped read 0x33", d, 0);
    rd(8'h5F, d); check("R8 unmapped read 0x5F", d, 0);
    rd(8'h31, d); check("R8 ch1 unchanged", d, 8'h10);
    rd(8'h5E, d); check("R8 cfg2 unchanged", d, 8'h40);

    // R7: mid-period change waits for the next period
    wr(8'h5C, 8'hE0);
    wr(8'h30, 8'h40);
    repeat (1100) @(negedge clk);
    prev = pwm_out[0];
    forever begin
      @(negedge clk);
      if (!prev && pwm_out[0]) break;
      prev = pwm_out[0];
    end
    hi = 1;
    for (int i = 1; i < 512; i++) begin
      @(negedge clk);
      if (i == 5) begin wr_en = 1'b1; addr = 8'h30; wdata = 8'hC0; end
      if (i == 6) wr_en = 1'b0;
      if (pwm_out[0]) hi++;
    end
    check("R7 current period keeps old duty", hi, 128);
    measure(0, hi);
    check("R7 next period uses new duty", hi, 384);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule